// File: doc/BRIEF.md
# Dual-Port Memory with Address-Collision Arbitration

This block is a synchronous two-port byte memory whose left and right sides are mirror images of each other. Each side has an enable, a write strobe, an address and write data, and either side may read or write any word. Reads return data one clock after they are accepted. The word count is a parameter: 15 address bits give the full 32K x 8 array, and the default is a smaller array so that elaboration stays light.

When both sides are enabled on the same word and at least one of them is writing, a collision detector decides who owns the word. The side that was already on that address in the previous cycle keeps access, and the newcomer sees its busy flag raised. If both arrive in the same cycle, a registered toggle picks the winner and alternates on every such tie so that neither side starves. A write made while busy does not touch the array. It is parked in a one-entry holding register on that side and carried out in the first cycle in which that side is no longer busy. A read made while busy gets no valid strobe, and the requester holds it until busy clears.

A mode input selects master or slave operation. In master mode the internal arbiter drives the busy flags. In slave mode each side's busy flag is taken from an external input, and the internal first-come decision has no effect.

Top module: `dpr_contention_ram`

## Requirements
- R1: A word written on a non-busy side is returned, when read, with the read valid strobe high one clock after the read is presented.
- R2: A word written through one side is readable with the same value through the opposite side.
- R3: In master mode a busy flag is high only while both sides are enabled on equal addresses with at least one writing. Two reads of the same word raise no busy flag, and the flag drops in the same cycle that the addresses differ or an enable falls.
- R4: In master mode, when a side was on an address in the previous cycle and the other side arrives there now, the newcomer's busy flag is high and the incumbent's is low. This holds with either side as the incumbent.
- R5: When both sides arrive on the same address in the same cycle, the first such tie after reset goes to the left side (right busy), and the winner alternates on every later tie.
- R6: A write presented while its side is busy does not change the array; reads of that word return the old value until the write is carried out.
- R7: A busy write is held and written into the array in the first cycle that its side's busy flag is low. The side's ready output is low from the clock after the deferral until that write retires, and any request presented while ready is low is ignored.
- R8: A read presented while its side is busy produces no valid strobe. Held until busy clears, it returns valid data one clock after the first non-busy cycle.
- R9: In slave mode (mode input low) each busy output equals that side's busy input, whatever the addresses are.
- R10: During reset both busy outputs are low, both ready outputs are high and both valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1: internal arbiter drives busy; 0: busy comes from the busy inputs |
| l_ce | input | 1 | Left side enable |
| l_we | input | 1 | Left side write strobe (0 = read) |
| l_addr | input | ADDR_W | Left side word address |
| l_wdata | input | DATA_W | Left side write data |
| l_rdata | output | DATA_W | Left side read data |
| l_rvalid | output | 1 | Left side read data valid |
| l_ready | output | 1 | Left side can accept a new request |
| l_busy_in | input | 1 | Left side external busy (slave mode) |
| l_busy_out | output | 1 | Left side busy flag in effect |
| r_ce | input | 1 | Right side enable |
| r_we | input | 1 | Right side write strobe (0 = read) |
| r_addr | input | ADDR_W | Right side word address |
| r_wdata | input | DATA_W | Right side write data |
| r_rdata | output | DATA_W | Right side read data |
| r_rvalid | output | 1 | Right side read data valid |
| r_ready | output | 1 | Right side can accept a new request |
| r_busy_in | input | 1 | Right side external busy (slave mode) |
| r_busy_out | output | 1 | Right side busy flag in effect |

## Verification
Busy flags are combinational on the present requests and on the state registered at the last edge, so the bench drives a request just after an edge and reads busy a nanosecond later, in the same cycle. Read data, valid strobes and ready are one register later, so they are read one nanosecond after the following rising edge. A deferred write lands on the edge that ends its first non-busy cycle, so it is observed through a read presented one cycle after that, whose data is read after the next edge again. Each contention scenario opens with an idle cycle, so that no side counts as the incumbent left over from an earlier scenario.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // A collision needs both sides enabled on one word and at least one writer.
  function automatic logic collide(input logic req_a, input logic we_a,
                                   input logic req_b, input logic we_b,
                                   input logic same_addr);
    return req_a & req_b & same_addr & (we_a | we_b);
  endfunction

  // The side already holding the address wins; otherwise the toggle decides.
  function automatic owner_e pick_first(input logic held_l, input logic held_r,
                                        input logic tie_right);
    if (held_l && !held_r) return OWN_LEFT;
    if (held_r && !held_l) return OWN_RIGHT;
    return tie_right ? OWN_RIGHT : OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              l_req,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_req,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in,
  input  logic              r_busy_in,
  output logic              l_busy,
  output logic              r_busy,
  output logic              collide_o,
  output logic              tie_o
);

  logic              prev_l_req, prev_r_req;
  logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
  owner_e            owner_q, winner;
  logic              tie_right_q;
  logic              held_l, held_r;

  always_comb begin
    collide_o = collide(l_req, l_we, r_req, r_we, l_addr == r_addr);
    held_l    = prev_l_req & l_req & (prev_l_addr == l_addr);
    held_r    = prev_r_req & r_req & (prev_r_addr == r_addr);
    tie_o     = collide_o & (owner_q == OWN_NONE) & (held_l == held_r);
    winner    = (owner_q != OWN_NONE) ? owner_q
                                      : pick_first(held_l, held_r, tie_right_q);
    l_busy    = master ? (collide_o & (winner == OWN_RIGHT)) : l_busy_in;
    r_busy    = master ? (collide_o & (winner == OWN_LEFT))  : r_busy_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l_req  <= 1'b0;
      prev_r_req  <= 1'b0;
      prev_l_addr <= '0;
      prev_r_addr <= '0;
      owner_q     <= OWN_NONE;
      tie_right_q <= 1'b0;
    end else begin
      prev_l_req  <= l_req;
      prev_r_req  <= r_req;
      prev_l_addr <= l_addr;
      prev_r_addr <= r_addr;
      owner_q     <= collide_o ? winner : OWN_NONE;
      if (tie_o) tie_right_q <= ~tie_right_q;
    end
  end

endmodule

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic              ready,
  output logic              eff_req,
  output logic              eff_we,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_en,
  output logic              rvalid
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              defer;

  // A parked write stands in for the port's request until it retires.
  always_comb begin
    ready     = ~pend_q;
    eff_req   = pend_q | ce;
    eff_we    = pend_q | (ce & we);
    eff_addr  = pend_q ? pend_addr_q : addr;
    mem_wdata = pend_q ? pend_data_q : wdata;
    mem_we    = eff_req & eff_we & ~busy;
    rd_en     = ~pend_q & ce & ~we & ~busy;
    defer     = ~pend_q & ce & we & busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      rvalid      <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (defer) begin
        pend_q      <= 1'b1;
        pend_addr_q <= addr;
        pend_data_q <= wdata;
      end else if (pend_q && !busy) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PORTS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PORTS-1:0]             we,
  input  logic [PORTS-1:0]             rd,
  input  logic [PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [PORTS-1:0][DATA_W-1:0] wdata,
  output logic [PORTS-1:0][DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        if (rd[p]) rdata[p] <= mem[addr[p]];
      end
    end
  end

endmodule

// File: rtl/dpr_contention_ram.sv
module dpr_contention_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_ready,
  input  logic              l_busy_in,
  output logic              l_busy_out,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_ready,
  input  logic              r_busy_in,
  output logic              r_busy_out
);

  localparam int NP = 2;

  logic [NP-1:0]             ce_v, we_v, busy_v, ready_v, rvalid_v;
  logic [NP-1:0]             eff_req_v, eff_we_v, mem_we_v, rd_en_v;
  logic [NP-1:0][ADDR_W-1:0] addr_v, eff_addr_v;
  logic [NP-1:0][DATA_W-1:0] wdata_v, mem_wdata_v, rdata_v;

  // Named internal events for the checker.
  logic l_mem_we, r_mem_we, collide_w, tie_w;

  assign ce_v    = {r_ce, l_ce};
  assign we_v    = {r_we, l_we};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master_mode),
    .l_req     (eff_req_v[0]),
    .l_we      (eff_we_v[0]),
    .l_addr    (eff_addr_v[0]),
    .r_req     (eff_req_v[1]),
    .r_we      (eff_we_v[1]),
    .r_addr    (eff_addr_v[1]),
    .l_busy_in (l_busy_in),
    .r_busy_in (r_busy_in),
    .l_busy    (busy_v[0]),
    .r_busy    (busy_v[1]),
    .collide_o (collide_w),
    .tie_o     (tie_w)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce        (ce_v[p]),
      .we        (we_v[p]),
      .addr      (addr_v[p]),
      .wdata     (wdata_v[p]),
      .busy      (busy_v[p]),
      .ready     (ready_v[p]),
      .eff_req   (eff_req_v[p]),
      .eff_we    (eff_we_v[p]),
      .eff_addr  (eff_addr_v[p]),
      .mem_we    (mem_we_v[p]),
      .mem_wdata (mem_wdata_v[p]),
      .rd_en     (rd_en_v[p]),
      .rvalid    (rvalid_v[p])
    );
  end

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(NP)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we_v),
    .rd    (rd_en_v),
    .addr  (eff_addr_v),
    .wdata (mem_wdata_v),
    .rdata (rdata_v)
  );

  assign l_mem_we   = mem_we_v[0];
  assign r_mem_we   = mem_we_v[1];
  assign l_rdata    = rdata_v[0];
  assign r_rdata    = rdata_v[1];
  assign l_rvalid   = rvalid_v[0];
  assign r_rvalid   = rvalid_v[1];
  assign l_ready    = ready_v[0];
  assign r_ready    = ready_v[1];
  assign l_busy_out = busy_v[0];
  assign r_busy_out = busy_v[1];

endmodule

// File: rtl/dpr_contention_ram_chk.sv
module dpr_contention_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic collide,
  input logic l_busy,
  input logic r_busy,
  input logic l_busy_in,
  input logic r_busy_in,
  input logic l_mem_we,
  input logic r_mem_we,
  input logic l_ready,
  input logic r_ready,
  input logic l_rvalid,
  input logic r_rvalid
);

  a_r3_busy_needs_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (l_busy || r_busy)) |-> collide);

  a_r4_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> !(l_busy && r_busy));

  a_r6_left_no_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy |-> !l_mem_we);

  a_r6_right_no_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |-> !r_mem_we);

  a_r7_left_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ready && !l_busy) |=> l_ready);

  a_r7_right_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ready && !r_busy) |=> r_ready);

  a_r8_left_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy |=> !l_rvalid);

  a_r8_right_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |=> !r_rvalid);

  a_r9_slave_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (l_busy == l_busy_in && r_busy == r_busy_in));

endmodule

bind dpr_contention_ram dpr_contention_ram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .master    (master_mode),
  .collide   (collide_w),
  .l_busy    (l_busy_out),
  .r_busy    (r_busy_out),
  .l_busy_in (l_busy_in),
  .r_busy_in (r_busy_in),
  .l_mem_we  (l_mem_we),
  .r_mem_we  (r_mem_we),
  .l_ready   (l_ready),
  .r_ready   (r_ready),
  .l_rvalid  (l_rvalid),
  .r_rvalid  (r_rvalid)
);

// File: tb/test_dpr_contention_ram.sv
module test_dpr_contention_ram;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master = 1'b1;
  logic          ce [2];
  logic          we [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic          bin [2];
  logic [DW-1:0] rd [2];
  logic          rv [2];
  logic          rdy [2];
  logic          busy [2];

  logic [DW-1:0] ref_mem [WORDS];
  int            checks = 0;
  int            fails = 0;

  always #10 clk = ~clk;

  dpr_contention_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_contention_ram (
    .clk (clk), .rst_n (rst_n), .master_mode (master),
    .l_ce (ce[0]), .l_we (we[0]), .l_addr (addr[0]), .l_wdata (wd[0]),
    .l_rdata (rd[0]), .l_rvalid (rv[0]), .l_ready (rdy[0]),
    .l_busy_in (bin[0]), .l_busy_out (busy[0]),
    .r_ce (ce[1]), .r_we (we[1]), .r_addr (addr[1]), .r_wdata (wd[1]),
    .r_rdata (rd[1]), .r_rvalid (rv[1]), .r_ready (rdy[1]),
    .r_busy_in (bin[1]), .r_busy_out (busy[1])
  );

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 11 + 5) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_all();
    for (int p = 0; p < 2; p++) begin
      ce[p] = 1'b0;
      we[p] = 1'b0;
    end
  endtask

  task automatic idle_edge();
    idle_all();
    tick();
  endtask

  task automatic wr(input int p, input int a, input logic [DW-1:0] d);
    ce[p] = 1'b1; we[p] = 1'b1; addr[p] = AW'(a); wd[p] = d;
    tick();
    ce[p] = 1'b0; we[p] = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic rd_chk(input int p, input int a, input string req);
    ce[p] = 1'b1; we[p] = 1'b0; addr[p] = AW'(a);
    tick();
    chk(req, rv[p], 1);
    chk(req, rd[p], ref_mem[a]);
    ce[p] = 1'b0;
  endtask

  // w is already on address a; o arrives one cycle later with a write.
  task automatic contend(input int w, input int a, input logic [DW-1:0] d);
    int o = 1 - w;
    int b = a ^ 1;
    idle_edge();
    ce[w] = 1'b1; we[w] = 1'b0; addr[w] = AW'(a);
    tick();
    ce[o] = 1'b1; we[o] = 1'b1; addr[o] = AW'(a); wd[o] = d;
    #1;
    chk("R4 newcomer busy", busy[o], 1);
    chk("R4 incumbent free", busy[w], 0);
    tick();
    chk("R6 old data on incumbent read", rd[w], ref_mem[a]);
    chk("R7 ready low while held", rdy[o], 0);
    addr[o] = AW'(b); wd[o] = ~d;          // R7: must be ignored
    #1;
    chk("R4 busy persists", busy[o], 1);
    tick();
    chk("R6 array unchanged", rd[w], ref_mem[a]);
    idle_all();
    #1;
    chk("R3 busy drops with enable", busy[o], 0);
    tick();
    chk("R7 ready back after retire", rdy[o], 1);
    ref_mem[a] = d;
    rd_chk(w, a, "R7 deferred write landed");
    rd_chk(o, b, "R7 stalled request ignored");
  endtask

  // w writes a and stays; o reads a from the next cycle on.
  task automatic read_under_busy(input int w, input int a, input logic [DW-1:0] d);
    int o = 1 - w;
    idle_edge();
    ce[w] = 1'b1; we[w] = 1'b1; addr[w] = AW'(a); wd[w] = d;
    tick();
    ref_mem[a] = d;
    ce[o] = 1'b1; we[o] = 1'b0; addr[o] = AW'(a);
    #1;
    chk("R8 reader busy", busy[o], 1);
    tick();
    chk("R8 no valid under busy", rv[o], 0);
    ce[w] = 1'b0; we[w] = 1'b0;
    #1;
    chk("R3 busy clears", busy[o], 0);
    tick();
    chk("R8 valid after clear", rv[o], 1);
    chk("R8 data after clear", rd[o], ref_mem[a]);
    ce[o] = 1'b0;
  endtask

  task automatic tie(input int winner, input int a);
    int loser = 1 - winner;
    logic [DW-1:0] dw = pat(a, 40 + winner);
    logic [DW-1:0] dl = pat(a, 50 + loser);
    idle_edge();
    for (int p = 0; p < 2; p++) begin
      ce[p] = 1'b1; we[p] = 1'b1; addr[p] = AW'(a);
    end
    wd[winner] = dw; wd[loser] = dl;
    #1;
    chk("R5 tie loser busy", busy[loser], 1);
    chk("R5 tie winner free", busy[winner], 0);
    tick();
    idle_all();
    tick();
    ref_mem[a] = dl;
    rd_chk(winner, a, "R5 loser write retired last");
  endtask

  initial begin
    idle_all();
    for (int p = 0; p < 2; p++) begin
      addr[p] = '0; wd[p] = '0; bin[p] = 1'b0;
    end
    for (int a = 0; a < WORDS; a++) ref_mem[a] = '0;
    tick();
    for (int p = 0; p < 2; p++) begin
      chk("R10 busy in reset", busy[p], 0);
      chk("R10 ready in reset", rdy[p], 1);
      chk("R10 rvalid in reset", rv[p], 0);
    end
    rst_n = 1'b1;
    tick();

    for (int a = 0; a < WORDS; a++) wr(0, a, pat(a, 1));
    for (int a = 0; a < WORDS; a++) rd_chk(1, a, "R2 left to right");
    for (int a = 0; a < WORDS; a++) wr(1, a, pat(a, 2));
    for (int a = 0; a < WORDS; a++) rd_chk(0, a, "R2 right to left");
    for (int a = 0; a < WORDS; a += 3) begin
      wr(0, a, pat(a, 3));
      rd_chk(0, a, "R1 same side");
    end

    idle_edge();
    for (int p = 0; p < 2; p++) begin
      ce[p] = 1'b1; we[p] = 1'b0; addr[p] = AW'(3);
    end
    #1;
    chk("R3 read-read left", busy[0], 0);
    chk("R3 read-read right", busy[1], 0);
    tick();
    for (int p = 0; p < 2; p++) begin
      chk("R3 read-read valid", rv[p], 1);
      chk("R3 read-read data", rd[p], ref_mem[3]);
    end
    idle_all();

    ce[0] = 1'b1; we[0] = 1'b1; addr[0] = AW'(4); wd[0] = 8'h11;
    ce[1] = 1'b1; we[1] = 1'b1; addr[1] = AW'(9); wd[1] = 8'h22;
    #1;
    chk("R3 distinct addr left", busy[0], 0);
    chk("R3 distinct addr right", busy[1], 0);
    tick();
    ref_mem[4] = 8'h11; ref_mem[9] = 8'h22;
    idle_all();
    rd_chk(1, 4, "R3 both writes landed");
    rd_chk(0, 9, "R3 both writes landed");

    tie(0, 6);
    tie(1, 7);
    tie(0, 8);

    contend(0, 5, 8'hA5);
    contend(1, 10, 8'h5A);
    read_under_busy(0, 12, 8'h3C);
    read_under_busy(1, 13, 8'hC3);

    idle_edge();
    master = 1'b0;
    bin[1] = 1'b1;
    ce[1] = 1'b1; we[1] = 1'b1; addr[1] = AW'(2); wd[1] = 8'h77;
    #1;
    chk("R9 right follows input", busy[1], 1);
    tick();
    chk("R7 slave deferral", rdy[1], 0);
    idle_all();
    ce[0] = 1'b1; we[0] = 1'b0; addr[0] = AW'(2);
    #1;
    chk("R9 internal decision ignored", busy[0], 0);
    tick();
    chk("R6 slave old data", rd[0], ref_mem[2]);
    chk("R9 slave read valid", rv[0], 1);
    ce[0] = 1'b0;
    bin[1] = 1'b0;
    #1;
    chk("R9 right input released", busy[1], 0);
    tick();
    ref_mem[2] = 8'h77;
    bin[0] = 1'b1;
    ce[0] = 1'b1; we[0] = 1'b0; addr[0] = AW'(2);
    #1;
    chk("R9 left follows input", busy[0], 1);
    tick();
    chk("R8 slave read held", rv[0], 0);
    bin[0] = 1'b0;
    tick();
    chk("R8 slave read valid", rv[0], 1);
    chk("R7 slave deferred landed", rd[0], ref_mem[2]);
    idle_all();
    master = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule